// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block widens a 16-bit CPU address into a 24-bit physical address. The top four bits of the CPU address pick one of sixteen 12-bit page registers. When translation is on, the chosen register's contents take the place of those four bits. The low twelve bits go through as they are. The result is 4 KiB pages placed anywhere in a 16 MiB physical space. When translation is off, the mapper is an identity map into the lowest 64 KiB.

Software reaches the block through two chip selects that share one read/write strobe (low means write) and one data input.

- **Page-register port:** with `map_cs` high, `reg_idx` picks the page register that is written or read.
- **Enable port:** with `ctl_cs` high, the global translation switch is written from data bit 0 or read back.

The translation path is purely combinational. It adds no cycle of latency between the CPU address and the physical address.

Top module: `page_mapper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears all sixteen page registers to 0 and clears the translation enable. After reset, `rdata` reads 0 for every page register and for the enable.
- R2: With the enable at 0, `page_out` equals `cpu_addr[15:12]` zero-extended to 12 bits. `phys_addr` is always `{page_out, cpu_addr[11:0]}` (bits 23:12 are the page, bits 11:0 the offset). So CPU address 0x0abc gives 0x000abc.
- R3: At a rising edge where `map_cs`=1 and `wr_n`=0, the page register numbered `reg_idx` takes `wdata`. No other page register changes.
- R4: At a rising edge where `ctl_cs`=1 and `wr_n`=0, the enable takes `wdata[0]`. Writing 1 turns translation on and writing 0 turns it off.
- R5: With the enable at 1, `page_out` equals the page register selected by `cpu_addr[15:12]`. With register 0 holding 0xcc, CPU address 0x0abc gives 0x0ccabc.
- R6: A page-register write made while the enable is 0 leaves `page_out` and `phys_addr` unchanged.
- R7: `page_out` and `phys_addr` follow a change of `cpu_addr` within the same clock cycle, with no clock edge in between. A page-register write becomes visible on `page_out` right after the edge that stores it.
- R8: With `map_cs`=1 and `wr_n`=1, `rdata` shows the page register selected by `reg_idx`.
- R9: With `ctl_cs`=1, `map_cs`=0 and `wr_n`=1, `rdata` shows the enable in bit 0 and zeros in bits 11:1.
- R10: When both chip selects are high with `wr_n`=1, the page-register read wins. When neither chip select is high, or `wr_n`=0, `rdata` is 0.
- R11: When both chip selects are high with `wr_n`=0 at one edge, both writes take effect. The page register takes `wdata` and the enable takes `wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| map_cs | input | 1 | Chip select for the page-register file |
| ctl_cs | input | 1 | Chip select for the translation enable |
| wr_n | input | 1 | Read/write strobe, 0 = write, 1 = read |
| reg_idx | input | 4 | Page-register number for writes and reads |
| wdata | input | 12 | Write data (enable uses bit 0) |
| rdata | output | 12 | Register readback |
| cpu_addr | input | 16 | CPU address to translate |
| page_out | output | 12 | Mapped page number |
| phys_addr | output | 24 | Physical address {page_out, cpu_addr[11:0]} |

## Verification
Two things can fall in one cycle, and the bench provokes both.

The first is a page-register write and an enable write at the same edge. Both chip selects are driven high with one data word whose bit 0 is 1, while the CPU address points at the entry being written. The bench checks that `page_out` still shows the identity page just before that edge, and shows the new register value just after it.

The second is rewriting the very entry that live translation is using. The bench samples the old mapping just before the edge and the new one just after it. This judges that the write never reaches the translation path early, and never reaches it late.

// File: rtl/page_mapper_pkg.sv
// Package: shared sizes and the readback source encoding for the page mapper.
// Assumes: a single clock domain; all consumers use these defaults unless overridden.
package page_mapper_pkg;
    localparam int unsigned CPU_AW_DEF = 16;
    localparam int unsigned IDX_W_DEF  = 4;
    localparam int unsigned PAGE_W_DEF = 12;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_PAGE = 2'd1,
        RD_CTL  = 2'd2
    } rd_src_e;
endpackage

// File: rtl/page_mapper_file.sv
// Module: page_mapper_file
// Holds the page registers and stores one entry per write strobe.
// Assumes: wr_en is already qualified by chip select and write strobe;
// reset is synchronous, active low, and clears every entry.
module page_mapper_file #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned PAGE_W = 12,
    localparam int unsigned N_PG  = 1 << IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [PAGE_W-1:0]             wr_data,
    output logic [N_PG-1:0][PAGE_W-1:0]   table_q
);
    logic [N_PG-1:0] hit;

    // Purpose: one-hot write decode of the target entry.
    always_comb begin
        hit = '0;
        if (wr_en) hit[wr_idx] = 1'b1;
    end

    for (genvar i = 0; i < N_PG; i++) begin : g_entry
        // Purpose: store one page register, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      table_q[i] <= '0;
            else if (hit[i]) table_q[i] <= wr_data;
        end

        // R3: a write to this entry lands next edge.
        assert_entry_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(i)) |=> table_q[i] == $past(wr_data));
        // R3: untargeted entries hold.
        assert_entry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(i)) |=> $stable(table_q[i]));
    end
endmodule

// File: rtl/page_mapper_ctl.sv
// Module: page_mapper_ctl
// Global translation enable bit.
// Assumes: wr_en is qualified by the enable chip select and write strobe.
module page_mapper_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic en_q
);
    // Purpose: hold the translation enable; reset turns translation off.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= wr_bit;
    end

    // R4: enable follows data bit 0 after a write.
    assert_en_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q == $past(wr_bit));
    // R1: enable is off on the first cycle after reset.
    assert_en_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !en_q);
endmodule

// File: rtl/page_mapper_xlate.sv
// Module: page_mapper_xlate
// Combinational translation of a CPU address to a physical address.
// Assumes: table and enable come from registers; no pipeline stage is added.
module page_mapper_xlate #(
    parameter int unsigned CPU_AW = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned PAGE_W = 12,
    localparam int unsigned N_PG  = 1 << IDX_W,
    localparam int unsigned OFF_W = CPU_AW - IDX_W,
    localparam int unsigned PHY_W = PAGE_W + OFF_W
) (
    input  logic [CPU_AW-1:0]             cpu_addr,
    input  logic                          en,
    input  logic [N_PG-1:0][PAGE_W-1:0]   table_q,
    output logic [PAGE_W-1:0]             page_out,
    output logic [PHY_W-1:0]              phys_addr
);
    logic [IDX_W-1:0] vpn;
    logic [OFF_W-1:0] off;

    // Purpose: split CPU address into page field and offset.
    always_comb begin
        vpn = cpu_addr[CPU_AW-1:OFF_W];
        off = cpu_addr[OFF_W-1:0];
    end

    // Purpose: pick mapped page or identity page, then join with offset.
    always_comb begin
        if (en) page_out = table_q[vpn];
        else    page_out = {{(PAGE_W-IDX_W){1'b0}}, vpn};
        phys_addr = {page_out, off};
    end
endmodule

// File: rtl/page_mapper_rd.sv
// Module: page_mapper_rd
// Readback multiplexer for page registers and the enable bit.
// Assumes: reads happen when wr_n is high; page read wins over enable read.
module page_mapper_rd
    import page_mapper_pkg::*;
#(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned PAGE_W = 12,
    localparam int unsigned N_PG  = 1 << IDX_W
) (
    input  logic                          map_cs,
    input  logic                          ctl_cs,
    input  logic                          wr_n,
    input  logic [IDX_W-1:0]              reg_idx,
    input  logic [N_PG-1:0][PAGE_W-1:0]   table_q,
    input  logic                          en,
    output logic [PAGE_W-1:0]             rdata
);
    rd_src_e src;

    // Purpose: choose readback source by chip select priority.
    always_comb begin
        if (!wr_n)       src = RD_NONE;
        else if (map_cs) src = RD_PAGE;
        else if (ctl_cs) src = RD_CTL;
        else             src = RD_NONE;
    end

    // Purpose: drive readback data for the chosen source.
    always_comb begin
        unique case (src)
            RD_PAGE: rdata = table_q[reg_idx];
            RD_CTL:  rdata = {{(PAGE_W-1){1'b0}}, en};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/page_mapper.sv
// Module: page_mapper (top)
// 16-entry page mapper: 16-bit CPU address to 24-bit physical address with a
// global translation enable. Assumes synchronous active-low reset, one clock.
module page_mapper
    import page_mapper_pkg::*;
#(
    parameter int unsigned CPU_AW = CPU_AW_DEF,
    parameter int unsigned IDX_W  = IDX_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF,
    localparam int unsigned N_PG  = 1 << IDX_W,
    localparam int unsigned OFF_W = CPU_AW - IDX_W,
    localparam int unsigned PHY_W = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_cs,
    input  logic              ctl_cs,
    input  logic              wr_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] rdata,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [PAGE_W-1:0] page_out,
    output logic [PHY_W-1:0]  phys_addr
);
    logic [N_PG-1:0][PAGE_W-1:0] table_q;
    logic                        en_q;
    logic                        pg_we;
    logic                        ctl_we;

    // Purpose: qualify write strobes per chip select (both may fire together).
    always_comb begin
        pg_we  = map_cs && !wr_n;
        ctl_we = ctl_cs && !wr_n;
    end

    page_mapper_file #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(pg_we), .wr_idx(reg_idx),
        .wr_data(wdata), .table_q(table_q)
    );

    page_mapper_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_bit(wdata[0]), .en_q(en_q)
    );

    page_mapper_xlate #(.CPU_AW(CPU_AW), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_xlate (
        .cpu_addr(cpu_addr), .en(en_q), .table_q(table_q),
        .page_out(page_out), .phys_addr(phys_addr)
    );

    page_mapper_rd #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_rd (
        .map_cs(map_cs), .ctl_cs(ctl_cs), .wr_n(wr_n), .reg_idx(reg_idx),
        .table_q(table_q), .en(en_q), .rdata(rdata)
    );

    // R2: with translation off, physical address stays in the lowest 64 KiB.
    assert_bypass_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> phys_addr[PHY_W-1:CPU_AW] == '0);
    // R2: offset always passes straight through.
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);
    // R6: while translation stays off, mapping depends only on the CPU address.
    assert_off_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $stable(en_q) && $stable(cpu_addr)) |-> $stable(page_out));
    // R10: no readback without a read chip select.
    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(map_cs || ctl_cs) || !wr_n) |-> rdata == '0);
endmodule

// File: tb/page_mapper_tb.sv
`timescale 1ns/1ps
module page_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        map_cs, ctl_cs, wr_n;
    logic [3:0]  reg_idx;
    logic [11:0] wdata;
    logic [11:0] rdata;
    logic [15:0] cpu_addr;
    logic [11:0] page_out;
    logic [23:0] phys_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [11:0] mdl_pg [16];
    logic        mdl_en;

    always #2.5 clk = ~clk;

    page_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .map_cs(map_cs), .ctl_cs(ctl_cs), .wr_n(wr_n),
        .reg_idx(reg_idx), .wdata(wdata), .rdata(rdata), .cpu_addr(cpu_addr),
        .page_out(page_out), .phys_addr(phys_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_page(input logic [15:0] a);
        return mdl_en ? mdl_pg[a[15:12]] : {8'h0, a[15:12]};
    endfunction

    // Drive a bus cycle at the falling edge, let one rising edge pass, release.
    task automatic bus_wr(input bit pg, input bit ctl, input logic [3:0] idx, input logic [11:0] d);
        @(negedge clk);
        map_cs = pg; ctl_cs = ctl; wr_n = 1'b0; reg_idx = idx; wdata = d;
        @(negedge clk);
        map_cs = 1'b0; ctl_cs = 1'b0; wr_n = 1'b1;
        if (pg)  mdl_pg[idx] = d;
        if (ctl) mdl_en = d[0];
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; map_cs = 0; ctl_cs = 0; wr_n = 1; reg_idx = 0; wdata = 0; cpu_addr = 16'h0abc;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        mdl_en = 1'b0;
        foreach (mdl_pg[i]) mdl_pg[i] = '0;
        #1;
        chk("R1 rdata idle", rdata, 0);
        map_cs = 1;
        for (int i = 0; i < 16; i++) begin
            reg_idx = 4'(i); #0.2;
            chk("R1 page reg cleared", rdata, 0);
        end
        map_cs = 0; ctl_cs = 1; #0.2;
        chk("R1 enable cleared", rdata, 0);
        ctl_cs = 0; #0.2;
    endtask

    task automatic t_bypass;
        cpu_addr = 16'h0abc; #0.5;
        chk("R2 phys 0x0abc off", phys_addr, 24'h000abc);
        cpu_addr = 16'hf123; #0.5;
        chk("R2 page zero-ext", page_out, 12'h00f);
        chk("R2 phys 0xf123 off", phys_addr, 24'h00f123);
    endtask

    task automatic t_write_off;
        cpu_addr = 16'h0abc;
        bus_wr(1, 0, 4'h0, 12'h0cc);
        chk("R6 write while off no effect", phys_addr, 24'h000abc);
        bus_wr(1, 0, 4'h7, 12'h9e1);
        cpu_addr = 16'h7001; #0.5;
        chk("R6 identity kept", phys_addr, 24'h007001);
    endtask

    task automatic t_enable;
        cpu_addr = 16'h0abc;
        bus_wr(0, 1, 4'h0, 12'h001);
        chk("R4 enable on / R5 map 0x0ccabc", phys_addr, 24'h0ccabc);
        cpu_addr = 16'h7321; #0.5;
        chk("R7 same-cycle addr change", page_out, 12'h9e1);
        chk("R5 phys entry 7", phys_addr, 24'h9e1321);
        bus_wr(0, 1, 4'h0, 12'hffe);
        chk("R4 enable off via bit0", phys_addr, 24'h007321);
        bus_wr(0, 1, 4'h0, 12'h001);
    endtask

    task automatic t_readback;
        bus_wr(1, 0, 4'h5, 12'ha5c);
        @(negedge clk); map_cs = 1; wr_n = 1; reg_idx = 4'h5; #1;
        chk("R8 read entry 5", rdata, 12'ha5c);
        reg_idx = 4'h7; #0.5;
        chk("R8 read entry 7", rdata, 12'h9e1);
        ctl_cs = 1; #0.5;
        chk("R10 page read priority", rdata, 12'h9e1);
        map_cs = 0; #0.5;
        chk("R9 enable read", rdata, 12'h001);
        wr_n = 0; ctl_cs = 0; map_cs = 0; #0.5;
        chk("R10 no read when writing", rdata, 0);
        wr_n = 1; #0.5;
        chk("R10 idle rdata", rdata, 0);
    endtask

    task automatic t_concurrent;
        bus_wr(0, 1, 4'h0, 12'h000);
        cpu_addr = 16'h3456;
        @(negedge clk);
        map_cs = 1; ctl_cs = 1; wr_n = 0; reg_idx = 4'h3; wdata = 12'h5a5;
        #1;
        chk("R7 old page before edge", page_out, 12'h003);
        @(negedge clk);
        map_cs = 0; ctl_cs = 0; wr_n = 1;
        mdl_pg[3] = 12'h5a5; mdl_en = 1'b1;
        #1;
        chk("R11 both writes landed", phys_addr, 24'h5a5456);
        @(negedge clk);
        map_cs = 1; wr_n = 0; reg_idx = 4'h3; wdata = 12'h111; #1;
        chk("R7 live entry old before edge", page_out, 12'h5a5);
        @(negedge clk); map_cs = 0; wr_n = 1; mdl_pg[3] = 12'h111; #1;
        chk("R3 live entry new after edge", page_out, 12'h111);
    endtask

    task automatic t_all_pages;
        for (int i = 0; i < 16; i++) bus_wr(1, 0, 4'(i), 12'(12'h100 + i * 17));
        for (int i = 0; i < 16; i++) begin
            cpu_addr = {4'(i), 12'h0f0}; #0.3;
            chk("R3 R5 sweep", phys_addr, {exp_page(cpu_addr), 12'h0f0});
        end
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_write_off();
        t_enable();
        t_readback();
        t_concurrent();
        t_all_pages();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule